// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block receives a two-slot serial audio stream as a pure clock slave. It runs on the incoming bit clock. On each rising edge of that clock it samples the frame-select line and the data line. From these it rebuilds one 24-bit sample per slot, using the framing and word length that a 4-bit format code selects. Three framings are decoded: I2S, MSB-first from the frame edge, and LSB-ending just before the frame edge. Each framing accepts words of 24, 20, 18 or 16 bits. Shorter words are left-aligned in the 24-bit result.

Once a frame is complete, two one-bit mapping inputs route the received slots onto the two output channels. The block then pulses a one-cycle valid strobe. A half-frame that is too short to carry a whole word is discarded, and it can raise an invalid-input flag that downstream stages use to mute. An optional holdoff makes the block ignore frame-select changes that come too soon after an accepted one, so a glitch or bounce cannot start an extra half-frame.

Top module: `sai_rx`

## Requirements
- R1: While `rst` is sampled high, and on the first cycle after it, `smp_valid` and `invalid_flag` are 0 and both sample outputs are all zeros.
- R2: The format code is split into two fields. `fmt[3:2]` selects the framing: 00 = I2S, 01 = MSB-first from the frame edge, 10 = LSB-ending, 11 = same as 00. `fmt[1:0]` selects the word length: 00 = 24, 01 = 20, 10 = 18, 11 = 16 bits.
- R3: In I2S framing the word MSB is the bit sampled one bit clock after the new `lrck` level is first sampled. The first slot is the half-frame with `lrck` = 0.
- R4: In MSB-first framing the word MSB is the bit sampled together with the first sample of the new `lrck` level. The first slot is the half with `lrck` = 1.
- R5: In LSB-ending framing the word LSB is the last bit sampled before the next `lrck` change. The first slot is the half with `lrck` = 1.
- R6: Words shorter than 24 bits appear with their MSB at output bit 23 and zeros below the LSB.
- R7: `map_ch0` and `map_ch1` each pick the slot for their channel: 0 = first slot, 1 = second slot. Both may pick the same slot.
- R8: `smp_valid` is high for exactly one cycle: the cycle in which the change ending the second slot is sampled. The sample outputs update only in that cycle.
- R9: Data before the first accepted `lrck` change after reset is discarded. A strobe needs a complete first slot followed by a complete second slot.
- R10: A half-frame shorter than the format needs (W bits, or W+1 bits for I2S framing) yields no strobe for its frame. If `inv_det_en` is 1, `invalid_flag` goes high on the cycle that half ends and stays high until the next strobe.
- R11: While `inv_det_en` is 0, `invalid_flag` is 0 one cycle later and stays 0.
- R12: With `guard_en` = 1, an `lrck` change sampled fewer than GUARD_BITS (default 8) bit clocks into a half-frame is ignored. With `guard_en` = 0, every change ends the half-frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock from the audio source; sampling edge is rising |
| rst | input | 1 | Synchronous active-high reset |
| lrck | input | 1 | Frame-select line |
| sdata | input | 1 | Serial data line |
| fmt | input | 4 | Framing [3:2] and word length [1:0] |
| map_ch0 | input | 1 | Slot feeding channel 0 |
| map_ch1 | input | 1 | Slot feeding channel 1 |
| guard_en | input | 1 | Enables the frame-select holdoff |
| inv_det_en | input | 1 | Enables the invalid-input flag |
| ch0_sample | output | 24 | Channel 0 sample, left-aligned |
| ch1_sample | output | 24 | Channel 1 sample, left-aligned |
| smp_valid | output | 1 | One-cycle strobe for a new sample pair |
| invalid_flag | output | 1 | Malformed input seen; mute request |

## Verification
Every result of this block is due in a single cycle: the rising edge at which the new `lrck` level is first sampled. At that edge the finished half-frame is judged. The strobe, the new sample pair and the rise of the flag are all visible right after that edge. The bench drives `lrck` and `sdata` on falling edges. A behavioural model keeps each half-frame as a queue of bits and advances on the same rising edge. Strobe, flag and both samples are compared against the model on every following falling edge, so any cycle shift is reported.

// File: rtl/sai_rx_pkg.sv
`timescale 1ns/1ps
package sai_rx_pkg;
    localparam int SAMPLE_W = 24;
    localparam int CNT_W    = 7;

    typedef enum logic [1:0] {
        FR_I2S       = 2'b00,
        FR_MSB_FIRST = 2'b01,
        FR_LSB_END   = 2'b10,
        FR_I2S_ALT   = 2'b11
    } framing_e;

    typedef enum logic [1:0] {
        WL_24 = 2'b00,
        WL_20 = 2'b01,
        WL_18 = 2'b10,
        WL_16 = 2'b11
    } wlen_e;

    typedef struct packed {
        framing_e framing;
        wlen_e    wlen;
    } fmt_t;

    typedef logic [CNT_W-1:0]    cnt_t;
    typedef logic [SAMPLE_W-1:0] sample_t;

    // Description of a half-frame that has just ended
    typedef struct packed {
        logic end_evt;
        logic lvl;
        cnt_t len;
    } half_info_t;

    function automatic cnt_t word_bits(input wlen_e wl);
        case (wl)
            WL_24:   return cnt_t'(24);
            WL_20:   return cnt_t'(20);
            WL_18:   return cnt_t'(18);
            default: return cnt_t'(16);
        endcase
    endfunction

    function automatic logic is_i2s(input framing_e fr);
        return (fr == FR_I2S) || (fr == FR_I2S_ALT);
    endfunction

    function automatic cnt_t need_bits(input fmt_t f);
        return word_bits(f.wlen) + (is_i2s(f.framing) ? cnt_t'(1) : cnt_t'(0));
    endfunction

    // lrck level carrying the first slot of a frame
    function automatic logic first_slot_lvl(input framing_e fr);
        return is_i2s(fr) ? 1'b0 : 1'b1;
    endfunction

    // Does the bit at half-frame position pos belong to the word?
    function automatic logic in_window(input fmt_t f, input cnt_t pos);
        cnt_t wb;
        wb = word_bits(f.wlen);
        if (f.framing == FR_LSB_END)   return 1'b1;
        if (f.framing == FR_MSB_FIRST) return pos < wb;
        return (pos >= cnt_t'(1)) && (pos <= wb);
    endfunction

    function automatic sample_t align_word(input sample_t raw, input wlen_e wl);
        cnt_t    pad;
        sample_t mask;
        pad  = cnt_t'(SAMPLE_W) - word_bits(wl);
        mask = {SAMPLE_W{1'b1}} >> pad;
        return (raw & mask) << pad;
    endfunction
endpackage

// File: rtl/sai_rx_edge_track.sv
`timescale 1ns/1ps
module sai_rx_edge_track
    import sai_rx_pkg::*;
#(
    parameter int GUARD_BITS = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       lrck,
    input  logic       guard_en,
    output logic       edge_acc,
    output cnt_t       pos,
    output half_info_t half
);
    localparam cnt_t GUARD_C = cnt_t'(GUARD_BITS);

    logic lvl_q;
    logic primed_q;
    logic started_q;
    cnt_t cnt_q;
    logic edge_raw;

    assign edge_raw = primed_q && (lrck != lvl_q);
    assign edge_acc = edge_raw && (!guard_en || (cnt_q >= GUARD_C));
    assign pos      = edge_acc ? '0 : cnt_q;

    assign half.end_evt = edge_acc && started_q;
    assign half.lvl     = lvl_q;
    assign half.len     = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q     <= 1'b0;
            primed_q  <= 1'b0;
            started_q <= 1'b0;
            cnt_q     <= '0;
        end else if (!primed_q) begin
            lvl_q    <= lrck;
            primed_q <= 1'b1;
            cnt_q    <= cnt_t'(1);
        end else if (edge_acc) begin
            lvl_q     <= lrck;
            started_q <= 1'b1;
            cnt_q     <= cnt_t'(1);
        end else if (cnt_q != {CNT_W{1'b1}}) begin
            cnt_q <= cnt_q + cnt_t'(1);
        end
    end

    AST_GUARD_HOLDOFF: assert property (@(posedge clk) disable iff (rst)
        (guard_en && edge_acc) |=> !edge_acc); // R12
endmodule

// File: rtl/sai_rx_shift.sv
`timescale 1ns/1ps
module sai_rx_shift
    import sai_rx_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    sdata,
    input  logic    edge_acc,
    input  cnt_t    pos,
    input  fmt_t    fmt,
    output sample_t word
);
    sample_t sh_q;
    logic    take;

    assign take = in_window(fmt, pos);
    assign word = align_word(sh_q, fmt.wlen);

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else if (edge_acc) begin
            sh_q <= take ? sample_t'(sdata) : '0;
        end else if (take) begin
            sh_q <= {sh_q[SAMPLE_W-2:0], sdata};
        end
    end
endmodule

// File: rtl/sai_rx_frame.sv
`timescale 1ns/1ps
module sai_rx_frame
    import sai_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  fmt_t       fmt,
    input  half_info_t half,
    input  sample_t    word,
    input  logic       map_ch0,
    input  logic       map_ch1,
    input  logic       inv_det_en,
    output sample_t    ch0_sample,
    output sample_t    ch1_sample,
    output logic       smp_valid,
    output logic       invalid_flag
);
    sample_t slot0_q;
    logic    got0_q;
    logic    bad_q;
    logic    half_ok;
    logic    is_first;
    logic    fire;

    assign half_ok  = half.len >= need_bits(fmt);
    assign is_first = (half.lvl == first_slot_lvl(fmt.framing));
    assign fire     = half.end_evt && !is_first && got0_q && !bad_q && half_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot0_q    <= '0;
            got0_q     <= 1'b0;
            bad_q      <= 1'b0;
            ch0_sample <= '0;
            ch1_sample <= '0;
            smp_valid  <= 1'b0;
        end else begin
            smp_valid <= fire;
            if (half.end_evt) begin
                if (is_first) begin
                    slot0_q <= word;
                    got0_q  <= 1'b1;
                    bad_q   <= !half_ok;
                end else begin
                    got0_q <= 1'b0;
                    bad_q  <= 1'b0;
                end
            end
            if (fire) begin
                ch0_sample <= map_ch0 ? word : slot0_q;
                ch1_sample <= map_ch1 ? word : slot0_q;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !inv_det_en) begin
            invalid_flag <= 1'b0;
        end else if (half.end_evt && !half_ok) begin
            invalid_flag <= 1'b1;
        end else if (fire) begin
            invalid_flag <= 1'b0;
        end
    end

    AST_NO_STROBE_ON_SHORT: assert property (@(posedge clk) disable iff (rst)
        (half.end_evt && !half_ok) |=> !smp_valid); // R10
    AST_FLAG_ON_SHORT: assert property (@(posedge clk) disable iff (rst)
        (half.end_evt && !half_ok && inv_det_en) |=> invalid_flag); // R10
    AST_FLAG_QUIET: assert property (@(posedge clk) disable iff (rst)
        !inv_det_en |=> !invalid_flag); // R11
    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (rst)
        smp_valid |=> !smp_valid); // R8
endmodule

// File: rtl/sai_rx.sv
`timescale 1ns/1ps
module sai_rx
    import sai_rx_pkg::*;
#(
    parameter int GUARD_BITS = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        lrck,
    input  logic        sdata,
    input  logic [3:0]  fmt,
    input  logic        map_ch0,
    input  logic        map_ch1,
    input  logic        guard_en,
    input  logic        inv_det_en,
    output logic [23:0] ch0_sample,
    output logic [23:0] ch1_sample,
    output logic        smp_valid,
    output logic        invalid_flag
);
    fmt_t       f;
    logic       edge_acc;
    cnt_t       pos;
    half_info_t half;
    sample_t    word;
    sample_t    c0;
    sample_t    c1;

    assign f          = fmt_t'(fmt);
    assign ch0_sample = c0;
    assign ch1_sample = c1;

    sai_rx_edge_track #(.GUARD_BITS(GUARD_BITS)) u_edge (
        .clk      (clk),
        .rst      (rst),
        .lrck     (lrck),
        .guard_en (guard_en),
        .edge_acc (edge_acc),
        .pos      (pos),
        .half     (half)
    );

    sai_rx_shift u_shift (
        .clk      (clk),
        .rst      (rst),
        .sdata    (sdata),
        .edge_acc (edge_acc),
        .pos      (pos),
        .fmt      (f),
        .word     (word)
    );

    sai_rx_frame u_frame (
        .clk          (clk),
        .rst          (rst),
        .fmt          (f),
        .half         (half),
        .word         (word),
        .map_ch0      (map_ch0),
        .map_ch1      (map_ch1),
        .inv_det_en   (inv_det_en),
        .ch0_sample   (c0),
        .ch1_sample   (c1),
        .smp_valid    (smp_valid),
        .invalid_flag (invalid_flag)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!smp_valid && !invalid_flag && ch0_sample == '0 && ch1_sample == '0)); // R1
    AST_HOLD_SAMPLES: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |-> ($stable(ch0_sample) && $stable(ch1_sample))); // R8
endmodule

// File: tb/sai_rx_bench.sv
`timescale 1ns/1ps
module sai_rx_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lrck = 1'b0;
    logic        sdata = 1'b0;
    logic [3:0]  fmt = 4'b0000;
    logic        map_ch0 = 1'b0;
    logic        map_ch1 = 1'b1;
    logic        guard_en = 1'b1;
    logic        inv_det_en = 1'b1;
    logic [23:0] ch0_sample;
    logic [23:0] ch1_sample;
    logic        smp_valid;
    logic        invalid_flag;

    localparam int GUARD = 8;

    int    n_checks = 0;
    int    n_fails  = 0;
    int    strobes  = 0;
    string cur_req  = "R1";
    bit    cmp_on   = 0;
    bit    done     = 0;

    always #2.5 clk = ~clk;

    sai_rx u_sai_rx (
        .clk(clk), .rst(rst), .lrck(lrck), .sdata(sdata), .fmt(fmt),
        .map_ch0(map_ch0), .map_ch1(map_ch1), .guard_en(guard_en),
        .inv_det_en(inv_det_en), .ch0_sample(ch0_sample), .ch1_sample(ch1_sample),
        .smp_valid(smp_valid), .invalid_flag(invalid_flag)
    );

    // ---------------- behavioural reference model ----------------
    bit          m_primed, m_started, m_got0, m_bad;
    logic        m_lvl;
    int          m_cnt;
    bit          m_bits[$];
    logic [23:0] m_slot0;
    logic        e_valid, e_flag;
    logic [23:0] e_ch0, e_ch1;

    function automatic int wlen_of(input logic [3:0] f);
        case (f[1:0])
            2'b00: return 24;
            2'b01: return 20;
            2'b10: return 18;
            default: return 16;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_primed = 0; m_started = 0; m_got0 = 0; m_bad = 0;
            m_lvl = 0; m_cnt = 0; m_bits.delete(); m_slot0 = '0;
            e_valid = 0; e_flag = 0; e_ch0 = '0; e_ch1 = '0;
        end else if (!m_primed) begin
            m_primed = 1; m_lvl = lrck; m_bits.delete(); m_bits.push_back(sdata);
            m_cnt = 1; e_valid = 0;
            if (!inv_det_en) e_flag = 0;
        end else begin
            e_valid = 0;
            if (lrck != m_lvl && (!guard_en || m_cnt >= GUARD)) begin
                if (m_started) begin
                    int  w, lead, n, first;
                    bit  ok, slot_first;
                    logic [23:0] val;
                    w    = wlen_of(fmt);
                    lead = (fmt[3:2] == 2'b00 || fmt[3:2] == 2'b11) ? 1 : 0;
                    n    = m_bits.size();
                    ok   = (n >= w + lead);
                    val  = '0;
                    if (ok) begin
                        first = (fmt[3:2] == 2'b10) ? n - w : lead;
                        for (int i = 0; i < w; i++) val = {val[22:0], m_bits[first + i]};
                        val = val << (24 - w);
                    end
                    slot_first = (lead == 1) ? (m_lvl == 0) : (m_lvl == 1);
                    if (slot_first) begin
                        m_slot0 = val; m_got0 = 1; m_bad = !ok;
                    end else begin
                        if (m_got0 && !m_bad && ok) begin
                            e_valid = 1;
                            e_ch0 = map_ch0 ? val : m_slot0;
                            e_ch1 = map_ch1 ? val : m_slot0;
                        end
                        m_got0 = 0; m_bad = 0;
                    end
                    if (!ok) e_flag = 1;
                    else if (e_valid) e_flag = 0;
                end
                m_started = 1; m_lvl = lrck; m_bits.delete(); m_bits.push_back(sdata); m_cnt = 1;
            end else begin
                m_bits.push_back(sdata);
                if (m_cnt < 127) m_cnt++;
            end
            if (!inv_det_en) e_flag = 0;
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on && !done) begin
            chk(cur_req, "smp_valid", int'(smp_valid), int'(e_valid));
            chk(cur_req, "invalid_flag", int'(invalid_flag), int'(e_flag));
            chk(cur_req, "ch0_sample", int'(ch0_sample), int'(e_ch0));
            chk(cur_req, "ch1_sample", int'(ch1_sample), int'(e_ch1));
            if (smp_valid) strobes++;
        end
    end

    // ---------------- stimulus ----------------
    task automatic do_reset(input logic [3:0] f);
        @(negedge clk);
        rst = 1; fmt = f;
        repeat (2) @(negedge clk);
        rst = 0;
    endtask

    task automatic send_half(input logic lvl, input int len, input logic [23:0] v, input bit glitch);
        int w, off;
        w   = wlen_of(fmt);
        off = (fmt[3:2] == 2'b10) ? len - w : (fmt[3:2] == 2'b01) ? 0 : 1;
        for (int p = 0; p < len; p++) begin
            @(negedge clk);
            lrck = (glitch && p == 2) ? ~lvl : lvl;
            if (p >= off && p < off + w) sdata = v[w - 1 - (p - off)];
            else sdata = 1'($urandom % 2);
        end
    endtask

    function automatic logic slot0_lvl();
        return (fmt[3:2] == 2'b00 || fmt[3:2] == 2'b11) ? 1'b0 : 1'b1;
    endfunction

    task automatic send_frames(input int count, input int len);
        for (int k = 0; k < count; k++) begin
            send_half(slot0_lvl(), len, 24'($urandom), 0);
            send_half(~slot0_lvl(), len, 24'($urandom), 0);
        end
    endtask

    task automatic start_stream();
        send_half(~slot0_lvl(), 20, 24'h0, 0);
    endtask

    task automatic finish_up();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1", "valid in reset", int'(smp_valid), 0);
        chk("R1", "flag in reset", int'(invalid_flag), 0);
        chk("R1", "ch0 in reset", int'(ch0_sample), 0);
        chk("R1", "ch1 in reset", int'(ch1_sample), 0);
        cmp_on = 1;

        // R3 I2S 24-bit
        cur_req = "R3"; strobes = 0;
        do_reset(4'b0000); start_stream(); send_frames(3, 32);
        send_half(slot0_lvl(), 8, 24'h0, 0);
        chk("R3", "strobes seen", strobes, 3);

        // R2 / R6 I2S 16-bit, alternate I2S code, 20-bit
        cur_req = "R6"; strobes = 0;
        do_reset(4'b0011); start_stream(); send_frames(2, 20);
        send_half(slot0_lvl(), 8, 24'h0, 0);
        chk("R6", "low byte zero", int'(ch0_sample[7:0]), 0);
        chk("R6", "strobes seen", strobes, 2);
        cur_req = "R2"; strobes = 0;
        do_reset(4'b1101); start_stream(); send_frames(2, 24);
        send_half(slot0_lvl(), 8, 24'h0, 0);
        chk("R2", "strobes seen", strobes, 2);

        // R4 MSB-first 24 and 18
        cur_req = "R4"; strobes = 0;
        do_reset(4'b0100); start_stream(); send_frames(2, 32);
        do_reset(4'b0110); start_stream(); send_frames(2, 18);
        send_half(slot0_lvl(), 8, 24'h0, 0);
        chk("R4", "strobes seen", strobes, 3);

        // R5 LSB-ending 24 exact length and 20 padded
        cur_req = "R5"; strobes = 0;
        do_reset(4'b1000); start_stream(); send_frames(2, 24);
        do_reset(4'b1001); start_stream(); send_frames(2, 32);
        send_half(slot0_lvl(), 8, 24'h0, 0);
        chk("R5", "strobes seen", strobes, 3);

        // R7 mapping swap and duplicate
        cur_req = "R7";
        do_reset(4'b0000); start_stream();
        map_ch0 = 1; map_ch1 = 0; send_frames(2, 32);
        map_ch0 = 1; map_ch1 = 1; send_frames(2, 32);
        map_ch0 = 0; map_ch1 = 0; send_frames(1, 32);
        map_ch1 = 1;

        // R9 startup without edge: first level is already slot 0
        cur_req = "R9"; strobes = 0;
        do_reset(4'b0100);
        send_half(1'b1, 30, 24'h0, 0);
        send_half(1'b0, 30, 24'h0, 0);
        send_half(1'b1, 30, 24'h0, 0);
        chk("R9", "no strobe before full frame", strobes, 0);

        // R10 short half with detection enabled
        cur_req = "R10"; strobes = 0;
        do_reset(4'b0000); start_stream(); send_frames(1, 32);
        send_half(1'b0, 24, 24'h123456, 0);
        send_half(1'b1, 32, 24'h0, 0);
        send_half(1'b0, 2, 24'h0, 0);
        chk("R10", "flag raised", int'(invalid_flag), 1);
        send_frames(1, 32);
        send_half(1'b0, 8, 24'h0, 0);
        chk("R10", "flag cleared by strobe", int'(invalid_flag), 0);

        // R11 detection disabled
        cur_req = "R11";
        inv_det_en = 0;
        send_half(1'b1, 32, 24'h0, 0);
        send_half(1'b0, 10, 24'h0, 0);
        send_half(1'b1, 32, 24'h0, 0);
        chk("R11", "flag stays low", int'(invalid_flag), 0);
        inv_det_en = 1;

        // R12 glitch with and without holdoff
        cur_req = "R12"; strobes = 0;
        do_reset(4'b0000); guard_en = 1; start_stream();
        send_half(1'b0, 32, 24'h0, 1);
        send_half(1'b1, 32, 24'h0, 1);
        send_half(1'b0, 8, 24'h0, 0);
        chk("R12", "glitch ignored", strobes, 1);
        chk("R12", "no flag on glitch", int'(invalid_flag), 0);
        guard_en = 0;
        send_half(1'b1, 32, 24'h0, 1);
        send_half(1'b0, 32, 24'h0, 1);
        chk("R12", "glitch counted", int'(invalid_flag), 1);
        send_frames(1, 32);
        guard_en = 1;

        cur_req = "R8";
        send_frames(2, 40);
        repeat (3) @(negedge clk);
        finish_up();
    end
endmodule